// File: doc/BRIEF.md
# Three-Bit Frame CRC Generator and Checker

This unit protects 32-bit command and response words with a short cyclic check. In generate mode it takes an outgoing request word, computes a 3-bit remainder over its upper 29 bits, and returns the word with that remainder written into the three least significant bits. In check mode it takes a received word and reports whether the word is acceptable. A word is acceptable when the remainder over all 32 bits comes out zero and the word does not raise two particular status bits at the same time.

The remainder uses the generator x^3 + x + 1 (0xB) and the register starts at 0b101. Bits are shifted in one at a time, most significant first, so the three check bits come last. When generating, the check field is treated as zero. A word accepted at the input appears on the registered outputs exactly one clock later. While no word is offered, the outputs keep their last value.

Top module: `crc3_frame_unit`

## Requirements
- R1: While `rst_n` is low, `res_vld`, `res_ok`, `res_crc` and `res_word` are all zero.
- R2: `res_vld` is high in the cycle after each cycle in which `in_vld` is high, and low otherwise.
- R3: In generate mode (`in_chk` = 0), `res_crc` is the remainder of (0b101·x^32 + W'(x)) modulo x^3+x+1. W' is the input word with bits 2:0 forced to zero, and bit 31 is the highest-order coefficient. The input's bits 2:0 have no effect. Generating over an all-zero word gives 3'b011.
- R4: In generate mode, `res_word[31:3]` equals input bits 31:3, and `res_word[2:0]` equals `res_crc`.
- R5: In check mode (`in_chk` = 1), `res_crc` is the remainder of (0b101·x^32 + W(x)) over the full word W. `res_ok` is 1 only when that remainder is zero and bits 31 and 3 of W are not both 1.
- R6: In check mode, `res_word` equals the input word unchanged.
- R7: In generate mode, `res_ok` is 0.
- R8: In a cycle with `in_vld` low, `res_word`, `res_crc` and `res_ok` keep their previous values on the next edge.
- R9: A word produced in generate mode is accepted in check mode (unless bits 31 and 3 are both 1), and inverting any single bit of it makes check mode reject it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A word is presented this cycle |
| in_chk | input | 1 | 0 = generate, 1 = check |
| in_word | input | 32 | Request or response word |
| res_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res_crc | output | 3 | Generated remainder, or check syndrome |
| res_ok | output | 1 | Check mode: word accepted |
| res_word | output | 32 | Word with remainder inserted (generate) or input copy (check) |

## Verification
The bench inverts each of the 32 bits of a valid word in turn. A design that fed its bits in the wrong order, or used the wrong taps, would miss some of these errors or reject the clean word.

The bench also drives the all-zero word, whose remainder is 3'b011, to catch a seed that is wrong or missing. It generates over words whose low three bits are nonzero, which exposes a design that lets the old check field leak into the remainder.

A word with a correct remainder but both status bits set must be rejected. Words with only one of those bits set must still be accepted, so a design that tests either bit alone is caught. Idle cycles between words show whether the outputs drift when nothing is offered.

// File: rtl/crc3_frame_unit.sv
module crc3_frame_unit #(
  parameter int FRAME_W = 32,
  parameter int CRC_W   = 3,
  parameter logic [CRC_W:0]   POLY = 4'hB,
  parameter logic [CRC_W-1:0] SEED = 3'h5,
  parameter int FLAG_HI = 31,
  parameter int FLAG_LO = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_chk,
  input  logic [FRAME_W-1:0] in_word,
  output logic               res_vld,
  output logic [CRC_W-1:0]   res_crc,
  output logic               res_ok,
  output logic [FRAME_W-1:0] res_word
);

  localparam logic [CRC_W-1:0] TAPS = POLY[CRC_W-1:0];

  function automatic logic [CRC_W-1:0] walk(input logic [FRAME_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic top;
    r = SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      top = r[CRC_W-1];
      r = {r[CRC_W-2:0], w[i]};
      if (top) r = r ^ TAPS;
    end
    return r;
  endfunction

  logic [FRAME_W-1:0] zeroed, feed, word_n;
  logic [CRC_W-1:0]   rem;
  logic               flags_bad, ok_n;

  assign zeroed    = {in_word[FRAME_W-1:CRC_W], {CRC_W{1'b0}}};
  assign feed      = in_chk ? in_word : zeroed;
  assign rem       = walk(feed);
  assign flags_bad = in_word[FLAG_HI] & in_word[FLAG_LO];
  assign ok_n      = in_chk & (rem == '0) & ~flags_bad;
  assign word_n    = in_chk ? in_word : {in_word[FRAME_W-1:CRC_W], rem};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_crc  <= '0;
      res_ok   <= 1'b0;
      res_word <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_crc  <= rem;
        res_ok   <= ok_n;
        res_word <= word_n;
      end
    end
  end

endmodule

// File: rtl/crc3_frame_unit_chk.sv
module crc3_frame_unit_chk #(
  parameter int FRAME_W = 32,
  parameter int CRC_W   = 3,
  parameter int FLAG_HI = 31,
  parameter int FLAG_LO = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_vld,
  input logic               in_chk,
  input logic [FRAME_W-1:0] in_word,
  input logic               res_vld,
  input logic [CRC_W-1:0]   res_crc,
  input logic               res_ok,
  input logic [FRAME_W-1:0] res_word
);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !res_vld);

  // R4
  gen_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_chk) |=>
      (res_word[FRAME_W-1:CRC_W] == $past(in_word[FRAME_W-1:CRC_W]))
      && (res_word[CRC_W-1:0] == res_crc));

  // R6
  chk_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_chk) |=> res_word == $past(in_word));

  // R7
  gen_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_chk) |=> !res_ok);

  // R5
  flag_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_chk && in_word[FLAG_HI] && in_word[FLAG_LO]) |=> !res_ok);

  // R5
  ok_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_ok) |-> res_crc == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res_word) && $stable(res_crc) && $stable(res_ok)));

endmodule

bind crc3_frame_unit crc3_frame_unit_chk #(
  .FRAME_W(FRAME_W), .CRC_W(CRC_W), .FLAG_HI(FLAG_HI), .FLAG_LO(FLAG_LO)
) u_chk (.*);

// File: tb/crc3_frame_unit_bench.sv
module crc3_frame_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        in_chk = 1'b0;
  logic [31:0] in_word = '0;
  logic        res_vld;
  logic [2:0]  res_crc;
  logic        res_ok;
  logic [31:0] res_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0]  crc;
    logic        ok;
    logic [31:0] word;
    string       req;
  } exp_t;

  exp_t sb[$];

  crc3_frame_unit u_crc3_frame_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_chk(in_chk),
    .in_word(in_word), .res_vld(res_vld), .res_crc(res_crc),
    .res_ok(res_ok), .res_word(res_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] ref_rem(input logic [31:0] w);
    logic [34:0] v;
    v = {3'b101, w};
    for (int k = 34; k >= 3; k--)
      if (v[k]) v[k -: 4] = v[k -: 4] ^ 4'b1011;
    return v[2:0];
  endfunction

  function automatic logic [31:0] ref_frame(input logic [31:0] w);
    return {w[31:3], ref_rem({w[31:3], 3'b000})};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_gen(input logic [31:0] w, input string req);
    exp_t e;
    @(negedge clk);
    in_vld = 1'b1; in_chk = 1'b0; in_word = w;
    e.crc = ref_rem({w[31:3], 3'b000});
    e.ok = 1'b0;
    e.word = {w[31:3], e.crc};
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic send_chk(input logic [31:0] w, input string req);
    exp_t e;
    @(negedge clk);
    in_vld = 1'b1; in_chk = 1'b1; in_word = w;
    e.crc = ref_rem(w);
    e.ok = (e.crc == 3'b000) && !(w[31] && w[3]);
    e.word = w;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_word = 32'hFFFF_FFFF;
      in_chk = ~in_chk;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual res_vld=1 expected 0 (no pending word)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " crc"},  64'(res_crc),  64'(e.crc));
        check({e.req, " ok"},   64'(res_ok),   64'(e.ok));
        check({e.req, " word"}, 64'(res_word), 64'(e.word));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] good, last;
    in_vld = 1'b1; in_chk = 1'b1; in_word = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R1
    check("R1 vld",  64'(res_vld),  64'd0);
    check("R1 ok",   64'(res_ok),   64'd0);
    check("R1 crc",  64'(res_crc),  64'd0);
    check("R1 word", 64'(res_word), 64'd0);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: no word offered yet
    check("R2 idle", 64'(res_vld), 64'd0);

    // R3 known vector: all-zero word gives 3'b011
    send_gen(32'h0000_0000, "R3");
    @(negedge clk); in_vld = 1'b0;
    @(negedge clk);
    check("R3 zero vector", 64'(res_crc), 64'h3);

    // R3 low bits ignored; R4 insertion
    send_gen(32'h1234_5670, "R3");
    send_gen(32'h1234_5677, "R3");
    send_gen(32'hA5A5_A5A5, "R4");
    send_gen(32'hFFFF_FFFF, "R4");
    // R7 and R5 over several patterns
    send_chk(32'h0000_0003, "R5");
    send_chk(32'h0000_0000, "R5");
    send_chk(ref_frame(32'h0F0F_0F00), "R5");
    send_chk(ref_frame(32'h8000_0000), "R5");
    send_chk(ref_frame(32'h0000_0008), "R5");
    send_chk(ref_frame(32'h8000_0008), "R5");
    send_chk(32'hDEAD_BEEF, "R6");
    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom;
      send_gen(r, "R7");
      send_chk(ref_frame(r & 32'h7FFF_FFFF), "R9");
    end

    // R9: single-bit flips over a clean frame
    good = ref_frame(32'h3C5A_9612);
    send_chk(good, "R9");
    for (int b = 0; b < 32; b++) send_chk(good ^ (32'h1 << b), "R9");

    // R8: idle cycles hold the last result
    send_gen(32'h0BAD_F00D, "R8");
    last = ref_frame(32'h0BAD_F00D);
    idle(4);
    check("R8 word", 64'(res_word), 64'(last));
    check("R8 vld",  64'(res_vld),  64'd0);
    idle(2);
    // R2: every offered word produced exactly one result
    check("R2 drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule